// File: doc/BRIEF.md
# Load-Use Hazard Interlock Unit

This block is the hazard control for a five-stage in-order pipeline in which the data-memory stage sits after the execute stage. A load's data is therefore not ready for the instruction that follows it directly. The block compares the destination of a load that is in execute with the source registers that the decoded instruction actually reads. When the decoded instruction needs the loaded value too early, the block holds the program counter and the fetch/decode register for one cycle. In that same cycle it sends a no-operation bubble into execute.

The block also chooses the operand source for the instruction in execute. It can take the register file, the memory-stage result or the writeback-stage result. The newer memory-stage result wins over the writeback result. A load that is still in the memory stage is never a forwarding source.

A mode input selects the older exposed-delay behaviour. In that mode no interlock is raised, and the instruction directly after a load sees the register's previous contents.

Top module: `lu_interlock`

## Requirements
- R1: In interlock mode (`delay_slot_i`=0), `stall_o` is 1 when the execute stage holds a load (`ex_is_load_i`=1) whose destination is nonzero and equals a source field that the decoded instruction reads. A source field counts as read when its enable (`id_use_rs1_i` or `id_use_rs2_i`) is 1.
- R2: A source field whose read enable is 0 never causes a stall, even when its register number matches.
- R3: Register 0 is never a dependency. No stall occurs when the load's destination is 0.
- R4: A non-load instruction in execute never causes a stall.
- R5: In delay-slot mode (`delay_slot_i`=1), `stall_o` stays 0 for every input pattern.
- R6: A stall lasts exactly one cycle. In the cycle after `stall_o` was 1, `stall_o` is 0 even if the inputs are unchanged. `pc_hold_o`, `ifid_hold_o` and `idex_bubble_o` all equal `stall_o`.
- R7: Each forwarding select uses the encoding 00 = register file, 01 = memory stage, 10 = writeback stage. The value 11 never appears. Index 0 of `fwd_sel_o` (bits [1:0]) serves `ex_rs1_i`, and index 1 (bits [3:2]) serves `ex_rs2_i`.
- R8: The memory stage is selected when it writes a nonzero register equal to the operand and it does not hold a load. This choice takes priority over the writeback stage.
- R9: Otherwise the writeback stage is selected when it writes a nonzero register equal to the operand. In every remaining case the select is 00. An operand of register 0 always selects 00.
- R10: While `rst_n` is low, `stall_o` follows R1 to R5 with no stall recorded as pending. After reset with idle inputs, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_slot_i | input | 1 | 1 selects exposed load delay (no interlock) |
| id_rs1_i | input | REG_AW | First source register of decoded instruction |
| id_rs2_i | input | REG_AW | Second source register of decoded instruction |
| id_use_rs1_i | input | 1 | Decoded instruction reads its first source |
| id_use_rs2_i | input | 1 | Decoded instruction reads its second source |
| ex_is_load_i | input | 1 | Execute stage holds a load |
| ex_rd_i | input | REG_AW | Destination of execute-stage instruction |
| ex_rs1_i | input | REG_AW | First source of execute-stage instruction |
| ex_rs2_i | input | REG_AW | Second source of execute-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_rd_i | input | REG_AW | Memory-stage destination |
| wb_wr_i | input | 1 | Writeback-stage instruction writes a register |
| wb_rd_i | input | REG_AW | Writeback-stage destination |
| stall_o | output | 1 | Load-use interlock active this cycle |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| idex_bubble_o | output | 1 | Insert a no-operation into execute |
| fwd_sel_o | output | 4 | Two 2-bit operand source selects |

## Verification
The bench sweeps every combination of a small register range, the two read enables, the load flag and the mode. This covers a match in only a disabled field, a register-0 destination, and a load in delay-slot mode. A design that got these wrong would stall on spurious dependencies or would stall where software expects the old value. Each stall is held for a second cycle with unchanged inputs, which catches a design that freezes the front end for good. The forwarding sweep covers both stages matching, register 0, and a load sitting in the memory stage. A design that got these wrong would pick stale writeback data or would forward memory data before it exists.

// File: rtl/lu_interlock_pkg.sv
package lu_interlock_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int REG_AW = 5
) (
  input  logic              ex_is_load_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  output logic              hazard_o
);
  logic rd_live;
  logic hit1, hit2;

  always_comb begin
    rd_live  = ex_is_load_i && (ex_rd_i != '0);
    hit1     = id_use_rs1_i && (id_rs1_i == ex_rd_i);
    hit2     = id_use_rs2_i && (id_rs2_i == ex_rd_i);
    hazard_o = rd_live && (hit1 || hit2);
  end
endmodule

// File: rtl/lu_fwd_select.sv
module lu_fwd_select
  import lu_interlock_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              mem_wr_i,
  input  logic              mem_is_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              wb_wr_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  output fwd_sel_e          sel_o
);
  logic src_live, mem_hit, wb_hit;

  always_comb begin
    src_live = (src_i != '0);
    mem_hit  = src_live && mem_wr_i && !mem_is_load_i && (mem_rd_i == src_i);
    wb_hit   = src_live && wb_wr_i && (wb_rd_i == src_i);
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
  import lu_interlock_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int N_OPS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 delay_slot_i,
  input  logic [REG_AW-1:0]    id_rs1_i,
  input  logic [REG_AW-1:0]    id_rs2_i,
  input  logic                 id_use_rs1_i,
  input  logic                 id_use_rs2_i,
  input  logic                 ex_is_load_i,
  input  logic [REG_AW-1:0]    ex_rd_i,
  input  logic [REG_AW-1:0]    ex_rs1_i,
  input  logic [REG_AW-1:0]    ex_rs2_i,
  input  logic                 mem_wr_i,
  input  logic                 mem_is_load_i,
  input  logic [REG_AW-1:0]    mem_rd_i,
  input  logic                 wb_wr_i,
  input  logic [REG_AW-1:0]    wb_rd_i,
  output logic                 stall_o,
  output logic                 pc_hold_o,
  output logic                 ifid_hold_o,
  output logic                 idex_bubble_o,
  output logic [2*N_OPS-1:0]   fwd_sel_o
);
  localparam int SEL_W = 2;

  logic hazard;
  logic stall_q, stall_d;
  logic stall_en;
  logic [REG_AW-1:0] ex_src [N_OPS];

  lu_hazard_detect #(.REG_AW(REG_AW)) u_detect (
    .ex_is_load_i (ex_is_load_i),
    .ex_rd_i      (ex_rd_i),
    .id_rs1_i     (id_rs1_i),
    .id_rs2_i     (id_rs2_i),
    .id_use_rs1_i (id_use_rs1_i),
    .id_use_rs2_i (id_use_rs2_i),
    .hazard_o     (hazard)
  );

  // A stall already taken last cycle lets the load advance; never repeat it.
  always_comb begin
    stall_o       = hazard && !delay_slot_i && !stall_q;
    pc_hold_o     = stall_o;
    ifid_hold_o   = stall_o;
    idex_bubble_o = stall_o;
    stall_d       = stall_o;
    stall_en      = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= 1'b0;
    else if (stall_en) stall_q <= stall_d;
  end

  always_comb begin
    ex_src[0] = ex_rs1_i;
    ex_src[1] = ex_rs2_i;
  end

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_fwd
      fwd_sel_e sel;
      lu_fwd_select #(.REG_AW(REG_AW)) u_sel (
        .src_i         (ex_src[g]),
        .mem_wr_i      (mem_wr_i),
        .mem_is_load_i (mem_is_load_i),
        .mem_rd_i      (mem_rd_i),
        .wb_wr_i       (wb_wr_i),
        .wb_rd_i       (wb_rd_i),
        .sel_o         (sel)
      );
      assign fwd_sel_o[g*SEL_W +: SEL_W] = sel;
    end
  endgenerate
endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              delay_slot_i,
  input logic              ex_is_load_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic [REG_AW-1:0] ex_rs1_i,
  input logic              mem_wr_i,
  input logic              mem_is_load_i,
  input logic [REG_AW-1:0] mem_rd_i,
  input logic              stall_o,
  input logic              pc_hold_o,
  input logic              ifid_hold_o,
  input logic              idex_bubble_o,
  input logic [3:0]        fwd_sel_o
);
  a_r4_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> ex_is_load_i);
  a_r5_no_stall_delay: assert property (@(posedge clk) disable iff (!rst_n)
    delay_slot_i |-> !stall_o);
  a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd_i == '0) |-> !stall_o);
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o);
  a_r6_holds_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold_o == stall_o) && (ifid_hold_o == stall_o) && (idex_bubble_o == stall_o));
  a_r7_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_o[1:0] != 2'b11) && (fwd_sel_o[3:2] != 2'b11));
  a_r8_mem_src_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_o[1:0] == 2'b01) |-> (mem_wr_i && !mem_is_load_i && mem_rd_i == ex_rs1_i));
  a_r9_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1_i == '0) |-> (fwd_sel_o[1:0] == 2'b00));
endmodule

bind lu_interlock lu_interlock_chk #(.REG_AW(REG_AW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .delay_slot_i  (delay_slot_i),
  .ex_is_load_i  (ex_is_load_i),
  .ex_rd_i       (ex_rd_i),
  .ex_rs1_i      (ex_rs1_i),
  .mem_wr_i      (mem_wr_i),
  .mem_is_load_i (mem_is_load_i),
  .mem_rd_i      (mem_rd_i),
  .stall_o       (stall_o),
  .pc_hold_o     (pc_hold_o),
  .ifid_hold_o   (ifid_hold_o),
  .idex_bubble_o (idex_bubble_o),
  .fwd_sel_o     (fwd_sel_o[3:0])
);

// File: tb/lu_interlock_tb.sv
module lu_interlock_tb_top;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic delay_slot, use1, use2, ex_ld, mem_wr, mem_ld, wb_wr;
  logic [AW-1:0] rs1, rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic stall, pc_hold, ifid_hold, bubble;
  logic [3:0] fwd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  lu_interlock #(.REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .delay_slot_i(delay_slot),
    .id_rs1_i(rs1), .id_rs2_i(rs2), .id_use_rs1_i(use1), .id_use_rs2_i(use2),
    .ex_is_load_i(ex_ld), .ex_rd_i(ex_rd), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .mem_wr_i(mem_wr), .mem_is_load_i(mem_ld), .mem_rd_i(mem_rd),
    .wb_wr_i(wb_wr), .wb_rd_i(wb_rd),
    .stall_o(stall), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .idex_bubble_o(bubble), .fwd_sel_o(fwd)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    delay_slot = 0; use1 = 0; use2 = 0; ex_ld = 0; mem_wr = 0; mem_ld = 0; wb_wr = 0;
    rs1 = 0; rs2 = 0; ex_rd = 0; ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; wb_rd = 0;
  endtask

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
    if (s != 0 && mem_wr && !mem_ld && mem_rd == s) return 2'b01;
    if (s != 0 && wb_wr && wb_rd == s) return 2'b10;
    return 2'b00;
  endfunction

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {stall, pc_hold, ifid_hold, bubble} | fwd, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {stall, pc_hold, ifid_hold, bubble} | fwd, 4'h0);

    // Stall sweep: R1 R2 R3 R4 R5 R6
    for (int m = 0; m < 2; m++)
      for (int ld = 0; ld < 2; ld++)
        for (int d = 0; d < 4; d++)
          for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
              for (int u = 0; u < 4; u++) begin
                logic e;
                idle();
                delay_slot = m[0]; ex_ld = ld[0]; ex_rd = AW'(d);
                rs1 = AW'(a); rs2 = AW'(b); use1 = u[0]; use2 = u[1];
                e = (m == 0) && (ld == 1) && (d != 0) &&
                    ((u[0] && a == d) || (u[1] && b == d));
                #1;
                check(m ? "R5 delay mode" : (ld == 0 ? "R4 non-load" :
                      (d == 0 ? "R3 reg zero" : "R1/R2 detect")),
                      {3'b0, stall}, {3'b0, e});
                check("R6 holds match stall", {1'b0, pc_hold, ifid_hold, bubble},
                      {1'b0, e, e, e});
                @(negedge clk);
                check("R6 single cycle", {3'b0, stall}, 4'h0);
                idle();
                @(negedge clk);
              end

    // Forwarding sweep: R7 R8 R9
    for (int s = 0; s < 4; s++)
      for (int mr = 0; mr < 4; mr++)
        for (int wr = 0; wr < 4; wr++)
          for (int f = 0; f < 8; f++) begin
            idle();
            ex_rs1 = AW'(s); ex_rs2 = AW'((s + 1) % 4);
            mem_rd = AW'(mr); wb_rd = AW'(wr);
            mem_wr = f[0]; mem_ld = f[1]; wb_wr = f[2];
            #1;
            check("R8/R9 fwd operand rs1 (R7 enc)", {2'b0, fwd[1:0]}, {2'b0, exp_sel(ex_rs1)});
            check("R8/R9 fwd operand rs2 (R7 enc)", {2'b0, fwd[3:2]}, {2'b0, exp_sel(ex_rs2)});
            @(negedge clk);
          end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule